// File: doc/BRIEF.md
# Hashed Page Table Group Search Engine

This block looks up one group of eight page table entries for the translation of a virtual page. A one-cycle `start` strobe hands it the memory address of the group, the virtual page number (already shifted right by 12), a 4-bit page-size index and a 2-bit segment-size code. On that strobe the block forms the comparison word from those three values and captures it. It then walks the group's first doublewords through a synchronous read port, issuing one read per cycle and testing each returned word as it arrives.

When a valid entry matches, the walk stops. The block fetches that entry's second doubleword and reports it together with the slot number and a one-cycle `done` strobe. If all eight slots fail, `done` fires with `hit` low. Producing the group address, retrying with the secondary hash, locking entries and inserting entries are handled elsewhere.

Entry `i` of a group at base `B` keeps its first doubleword at word address `B + 2*i` and its second at `B + 2*i + 1`. Addresses wrap modulo the address width.

Top module: `pte_group_search`

## Requirements
- R1: Immediately after reset, `done`, `hit` and `mem_req` are all low.
- R2: A search reads first doublewords in ascending slot order, one read per cycle, from word address base + 2*slot. It stops issuing them once the slot after a hit has been requested, or after slot 7.
- R3: An entry matches the comparison word when bits 63:7 of the two are equal. Bits 6:0 play no part in the compare.
- R4: Bit 0 of the first doubleword is the valid flag. An entry with bit 0 clear never hits, whatever its other bits hold.
- R5: When several slots would hit, the lowest-numbered one is reported.
- R6: On a hit at slot k, the block reads word address base + 2*k + 1 and raises `done` with `hit` high, `hit_slot` = k and `hit_dw2` = that word. This happens on the (k+4)th rising edge after the edge that samples `start`.
- R7: When no slot hits, `done` rises with `hit` low on the 9th rising edge after the edge that samples `start`.
- R8: The comparison word, shown on `match_word`, is built as follows. With m = the mask table entry selected by the page-size index, bits 61:7 hold the low 55 bits of ((vpn >> 11) & ~m). Bits 63:62 hold the segment-size code, where 0 is 256 MB, 1 is 1 TB, and 2 and 3 are reserved and passed through. Bit 2 is set exactly when the page-size index differs from `PSIZE_SMALL` (0, the 4 KB size). All other bits are 0. With the default mask table, index 1 masks vpn bits 19:11 and every other index masks nothing.
- R9: A `start` that arrives while a search is running is ignored and leaves the running search's results and `match_word` unchanged. A `start` in the cycle where `done` is high is accepted.
- R10: `done` is high for exactly one cycle. `hit`, `hit_slot` and `hit_dw2` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a group search; sampled only when idle |
| grp_base | input | ADDR_W | Word address of slot 0's first doubleword |
| vpn | input | 64 | Virtual page number, pre-shifted right by 12 |
| psize_idx | input | PSZ_W | Page-size index into the mask table |
| seg_code | input | 2 | Segment-size code |
| mem_req | output | 1 | Read strobe to the entry memory |
| mem_addr | output | ADDR_W | Read word address |
| mem_rdata | input | DW_W | Read data, valid one cycle after `mem_req` |
| done | output | 1 | One-cycle completion strobe |
| hit | output | 1 | Search found a valid matching entry |
| hit_slot | output | 3 | Slot number of the hit |
| hit_dw2 | output | DW_W | Second doubleword of the hitting entry |
| match_word | output | DW_W | Comparison word captured at start |

## Verification
Two events can land in the same cycle. The first is the completion strobe of one search together with the `start` of the next. The bench issues every search straight after the previous `done`, so the new strobe is sampled while `done` is still high. Each result must then match the bench's own model, and its latency must be exact. The second case is a `start` that arrives mid-search. It is injected on the third cycle of some searches, and the outcome and `match_word` of the running search must not change.

// File: rtl/ptegrp_pkg.sv
package ptegrp_pkg;
    localparam int GROUP_SLOTS = 8;
    localparam int SLOT_W      = $clog2(GROUP_SLOTS);
    localparam int FLAG_BITS   = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FETCH = 2'd2,
        ST_LAND  = 2'd3
    } walk_st_e;
endpackage

// File: rtl/ptegrp_tag_build.sv
module ptegrp_tag_build #(
    parameter int DW_W        = 64,
    parameter int PSZ_W       = 4,
    parameter int PSIZE_SMALL = 0,
    parameter logic [(2**PSZ_W)-1:0][DW_W-1:0] MASKS = '0
) (
    input  logic [63:0]      vpn,
    input  logic [PSZ_W-1:0] psize_idx,
    input  logic [1:0]       seg_code,
    output logic [DW_W-1:0]  tag
);
    localparam int AV_W      = DW_W - 9;
    localparam int VPN_DROP  = 11;
    localparam int LARGE_BIT = 2;

    logic [AV_W-1:0] av_raw;
    logic [AV_W-1:0] av_keep;

    always_comb begin
        av_raw  = AV_W'(vpn >> VPN_DROP);
        av_keep = av_raw & ~AV_W'(MASKS[psize_idx]);
        tag     = '0;
        tag[DW_W-1 -: 2]              = seg_code;
        tag[ptegrp_pkg::FLAG_BITS +: AV_W] = av_keep;
        tag[LARGE_BIT] = (psize_idx != PSZ_W'(PSIZE_SMALL));
    end
endmodule

// File: rtl/ptegrp_slot_match.sv
module ptegrp_slot_match #(
    parameter int DW_W = 64
) (
    input  logic [DW_W-1:0] entry,
    input  logic [DW_W-1:0] target,
    output logic            hit
);
    localparam logic [DW_W-1:0] FLAG_MASK = DW_W'((1 << ptegrp_pkg::FLAG_BITS) - 1);

    logic [DW_W-1:0] diff;

    always_comb begin
        diff = (entry ^ target) & ~FLAG_MASK;
        hit  = entry[0] && (diff == '0);
    end
endmodule

// File: rtl/pte_group_search.sv
module pte_group_search
    import ptegrp_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DW_W        = 64,
    parameter int PSZ_W       = 4,
    parameter int PSIZE_SMALL = 0,
    parameter logic [(2**PSZ_W)-1:0][DW_W-1:0] AVPN_MASKS =
        {{14{64'h0}}, 64'h0000_0000_0000_01FF, 64'h0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] grp_base,
    input  logic [63:0]       vpn,
    input  logic [PSZ_W-1:0]  psize_idx,
    input  logic [1:0]        seg_code,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DW_W-1:0]   mem_rdata,
    output logic              done,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic [DW_W-1:0]   hit_dw2,
    output logic [DW_W-1:0]   match_word
);
    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] base;
        logic [DW_W-1:0]   tgt;
        logic [SLOT_W:0]   ridx;
        logic              cv;
        logic [SLOT_W-1:0] cidx;
        logic [SLOT_W-1:0] slot;
        logic              done;
        logic              hit;
        logic [DW_W-1:0]   dw2;
    } walk_t;

    walk_t d, q;
    logic [DW_W-1:0] tag_w;
    logic            slot_hit;

    ptegrp_tag_build #(
        .DW_W(DW_W), .PSZ_W(PSZ_W), .PSIZE_SMALL(PSIZE_SMALL), .MASKS(AVPN_MASKS)
    ) u_tag (
        .vpn(vpn), .psize_idx(psize_idx), .seg_code(seg_code), .tag(tag_w)
    );

    ptegrp_slot_match #(.DW_W(DW_W)) u_cmp (
        .entry(mem_rdata), .target(q.tgt), .hit(slot_hit)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        mem_req  = 1'b0;
        mem_addr = q.base;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_SCAN;
                    d.base = grp_base;
                    d.tgt  = tag_w;
                    d.ridx = '0;
                    d.cv   = 1'b0;
                    d.hit  = 1'b0;
                end
            end
            ST_SCAN: begin
                mem_req  = !q.ridx[SLOT_W];
                mem_addr = q.base + ADDR_W'({q.ridx[SLOT_W-1:0], 1'b0});
                if (mem_req) d.ridx = q.ridx + 1'b1;
                d.cv   = mem_req;
                d.cidx = q.ridx[SLOT_W-1:0];
                if (q.cv) begin
                    if (slot_hit) begin
                        d.slot = q.cidx;
                        d.cv   = 1'b0;
                        d.st   = ST_FETCH;
                    end else if (&q.cidx) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.hit  = 1'b0;
                    end
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.base + ADDR_W'({q.slot, 1'b1});
                d.st     = ST_LAND;
            end
            ST_LAND: begin
                d.dw2  = mem_rdata;
                d.hit  = 1'b1;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done       = q.done;
    assign hit        = q.hit;
    assign hit_slot   = q.slot;
    assign hit_dw2    = q.dw2;
    assign match_word = q.tgt;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !mem_req);
    // R6
    land_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LAND) |=> (done && hit));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && start) |=> $stable(match_word));
    // R5
    fetch_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH) |=> $stable(hit_slot));
endmodule

// File: tb/pte_group_search_test.sv
module pte_group_search_test;
    localparam logic [15:0][63:0] TB_MASKS =
        {{14{64'h0}}, 64'h0000_0000_0000_01FF, 64'h0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] grp_base = '0;
    logic [63:0] vpn = '0;
    logic [3:0]  psize_idx = '0;
    logic [1:0]  seg_code = '0;
    logic        mem_req;
    logic [11:0] mem_addr;
    logic [63:0] mem_rdata = '0;
    logic        done, hit;
    logic [2:0]  hit_slot;
    logic [63:0] hit_dw2, match_word;

    logic [63:0] mem [4096];
    logic [11:0] rlog [32];
    int rcnt = 0;
    int ncmp = 0;
    int nbad = 0;

    always #5 clk = ~clk;

    pte_group_search #(.ADDR_W(12), .DW_W(64), .PSZ_W(4), .PSIZE_SMALL(0),
                       .AVPN_MASKS(TB_MASKS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .grp_base(grp_base),
        .vpn(vpn), .psize_idx(psize_idx), .seg_code(seg_code),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .hit(hit), .hit_slot(hit_slot), .hit_dw2(hit_dw2),
        .match_word(match_word)
    );

    always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr];
    always @(negedge clk) if (mem_req && rcnt < 32) begin rlog[rcnt] = mem_addr; rcnt++; end

    function automatic logic [63:0] ref_tag(logic [63:0] v, logic [3:0] p, logic [1:0] s);
        logic [63:0] sh = (v >> 11) & ~TB_MASKS[p];
        logic [63:0] t = '0;
        t[63:62] = s;
        t[61:7]  = sh[54:0];
        t[2]     = (p != 4'd0);
        return t;
    endfunction

    function automatic bit ref_match(logic [63:0] e, logic [63:0] t);
        return e[0] && (e[63:7] == t[63:7]);
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        ncmp++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic fill(logic [11:0] b);
        for (int s = 0; s < 8; s++) begin
            mem[12'(b + 12'(2*s))]   = rnd64();
            mem[12'(b + 12'(2*s+1))] = rnd64();
        end
    endtask

    task automatic plant(logic [11:0] b, int s, logic [63:0] t, bit valid);
        logic [6:0] lo = 7'($urandom);
        lo[0] = valid;
        mem[12'(b + 12'(2*s))] = {t[63:7], lo};
    endtask

    task automatic search(logic [11:0] b, logic [63:0] v, logic [3:0] p,
                          logic [1:0] s, bit poke);
        logic [63:0] t = ref_tag(v, p, s);
        int k = -1;
        int n = 0;
        int nexp;
        for (int i = 0; i < 8; i++)
            if (k < 0 && ref_match(mem[12'(b + 12'(2*i))], t)) k = i;
        grp_base = b; vpn = v; psize_idx = p; seg_code = s; start = 1'b1;
        rcnt = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (poke && n == 3) begin
                start = 1'b1; vpn = ~v; grp_base = b + 12'd40; psize_idx = p ^ 4'd1;
            end else start = 1'b0;
            if (done || n > 40) break;
        end
        start = 1'b0;
        chk("R8 match_word", match_word, t);
        if (poke) chk("R9 busy start ignored", match_word, t);
        if (k >= 0) begin
            chk("R6 latency", 64'(n), 64'(k + 5));
            chk("R6 hit", 64'(hit), 64'd1);
            chk("R5 slot", 64'(hit_slot), 64'(k));
            chk("R6 dw2", hit_dw2, mem[12'(b + 12'(2*k+1))]);
            nexp = (k == 7) ? 9 : k + 3;
        end else begin
            chk("R7 latency", 64'(n), 64'd10);
            chk("R7 hit low", 64'(hit), 64'd0);
            nexp = 8;
        end
        chk("R2 read count", 64'(rcnt), 64'(nexp));
        for (int i = 0; i < nexp && i < rcnt; i++) begin
            if (k >= 0 && i == nexp - 1)
                chk("R6 second read addr", 64'(rlog[i]), 64'(12'(b + 12'(2*k+1))));
            else
                chk("R2 read order", 64'(rlog[i]), 64'(12'(b + 12'(2*i))));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL R6 watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

    initial begin
        logic [63:0] v, t;
        logic [11:0] b;
        logic [3:0]  p;
        logic [1:0]  s;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 done", 64'(done), 0);
        chk("R1 hit", 64'(hit), 0);
        chk("R1 mem_req", 64'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: hit at slot 0
        b = 12'h100; v = rnd64(); t = ref_tag(v, 0, 0);
        fill(b); plant(b, 0, t, 1); search(b, v, 0, 0, 0);
        // R6/R2: hit at last slot
        fill(b); plant(b, 7, t, 1); search(b, v, 0, 1, 0);
        t = ref_tag(v, 0, 1); plant(b, 7, t, 1); search(b, v, 0, 1, 0);
        // R7: no match anywhere
        fill(b); search(b, v, 0, 0, 0);
        // R4: invalid lower copy skipped, valid copy at slot 5 wins
        t = ref_tag(v, 0, 0); fill(b);
        plant(b, 2, t, 0); plant(b, 5, t, 1); search(b, v, 0, 0, 0);
        // R4: only an invalid copy gives a miss
        fill(b); plant(b, 4, t, 0); search(b, v, 0, 0, 0);
        // R5: two valid copies, lower wins
        fill(b); plant(b, 6, t, 1); plant(b, 3, t, 1); search(b, v, 0, 0, 0);
        // R3: differing only in bit 7 is a miss
        fill(b); mem[b + 12'd2] = {t[63:8], ~t[7], 7'h01}; search(b, v, 0, 0, 0);
        // R3: low flag bits differ but upper equal is a hit
        mem[b + 12'd2] = {t[63:7], 7'h7F}; search(b, v, 0, 0, 0);
        chk("R3 low bits ignored", 64'(hit), 64'd1);
        // R8: large size masks vpn bits 19:11; flipping bit 14 still hits
        b = 12'hFF8; t = ref_tag(v, 4'd1, 2'd3); fill(b); plant(b, 1, t, 1);
        chk("R8 large bit", 64'(t[2]), 64'd1);
        search(b, v ^ 64'h4000, 4'd1, 2'd3, 0);
        chk("R8 masked bit ignored", 64'(hit), 64'd1);
        // R8: small size does not mask bit 14 → miss
        t = ref_tag(v, 4'd0, 2'd3); fill(b); plant(b, 1, t, 1);
        search(b, v ^ 64'h4000, 4'd0, 2'd3, 0);
        chk("R8 small size unmasked", 64'(hit), 64'd0);
        // R9: start during a search is ignored
        b = 12'h200; t = ref_tag(v, 0, 0); fill(b); plant(b, 6, t, 1);
        search(b, v, 0, 0, 1);
        fill(b); search(b, v, 0, 0, 1);
        // R10: pulse width and held results
        fill(b); plant(b, 2, t, 1); search(b, v, 0, 0, 0);
        @(negedge clk);
        chk("R10 done one cycle", 64'(done), 0);
        chk("R10 hit held", 64'(hit), 1);
        chk("R10 slot held", 64'(hit_slot), 2);
        chk("R10 dw2 held", hit_dw2, mem[b + 12'd5]);

        // random searches, issued back-to-back (R9 accept on done)
        for (int it = 0; it < 120; it++) begin
            b = 12'($urandom);
            v = rnd64();
            p = ($urandom % 3 == 0) ? 4'd1 : 4'($urandom);
            s = 2'($urandom);
            t = ref_tag(v, p, s);
            fill(b);
            if ($urandom % 4 != 0) plant(b, int'($urandom % 8), t, 1);
            if ($urandom % 3 == 0) plant(b, int'($urandom % 8), t, 0);
            search(b, v, p, s, ($urandom % 5) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end
endmodule